// File: doc/BRIEF.md
# Flash Write-Engine Status Register with Sticky Errors and Read Capture

This block keeps the 8-bit status word of a flash program/erase engine and presents it on the 16-bit host data bus. The engine reports its progress through one busy level and two pulse vectors, one that sets status bits and one that clears them. The engine may clear only the two non-error flags, bits 2 and 6. The four error flags, bits 1, 3, 4 and 5, stay set until the host issues the clear-status command (50h). This block receives that command as a one-cycle strobe from the command decoder.

Bus reads are synchronous to the block clock and use the active-low chip enable and output enable. When both enables become low, whichever falls last, the block captures the status word. It then holds that value for the whole read. A status change that happens during a read, including completion of an operation, appears only after an enable is raised and lowered again. The upper data byte is always zero, and the bus reads zero while no read is in progress.

Top module: `flsr_status`

## Requirements
- R1: After synchronous reset the status word is 80h (ready, no flags), and `dq` reads 0000h until a read begins. A read right after reset returns 0080h.
- R2: Bit 7 is the ready flag. At each clock edge it takes the inverse of `eng_busy` (1 = ready).
- R3: Error bits 1, 3, 4 and 5 are set by the matching `eng_set` bit. A pulse on `eng_clr` does not clear them.
- R4: A pulse on `clr_cmd` clears bits 1, 3, 4 and 5 and leaves bits 2, 6 and 7 unchanged.
- R5: Bits 2 and 6 are set by `eng_set` and cleared by `eng_clr`. When both arrive for one of these bits in the same cycle, the bit ends up set.
- R6: When `eng_set` and `clr_cmd` arrive in the same cycle, the set bits end up set.
- R7: Bit 0 is reserved and always reads 0, even when `eng_set[0]` is pulsed.
- R8: At the first clock edge where `ce_n` and `oe_n` are both low, the block captures the status word present before that edge. From the next cycle `dq[7:0]` shows the captured value, and it holds that value while both enables stay low.
- R9: The cycle after a clock edge at which `ce_n` or `oe_n` was high, `dq` is 0000h.
- R10: `dq[15:8]` is always 00h.
- R11: A status change made during a held read is not visible until an enable has been high for at least one edge and both have gone low again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| eng_set | input | 8 | Engine set pulses, one per status bit |
| eng_clr | input | 8 | Engine clear pulses, honoured on bits 2 and 6 only |
| eng_busy | input | 1 | Engine busy level; bit 7 reads its inverse |
| clr_cmd | input | 1 | One-cycle strobe from the decoder for clear-status (50h) |
| ce_n | input | 1 | Chip enable, active low, synchronous to clk |
| oe_n | input | 1 | Output enable, active low, synchronous to clk |
| dq | output | 16 | Read data: captured status on the low byte, zero otherwise |

## Verification
The hardest case to reach from the ports is a status update that lands while a read is held open, followed by an enable toggle that must expose it. A related case is a read whose enables fall in separate cycles, with the status changing between the two falls. Directed sequences keep both enables low across engine updates and busy changes, and they lower the output enable cycles before the chip enable. Long random runs bias the enables toward staying low, so held reads overlap with set, clear and clear-command pulses, including same-cycle conflicts.

// File: rtl/flsr_pkg.sv
package flsr_pkg;

    localparam int STAT_W = 8;
    localparam int BUS_W  = 16;
    localparam int RDY_IDX = 7;

    // bits the engine can raise, bits it may drop, bits only 50h drops
    localparam logic [STAT_W-1:0] SET_MASK     = 8'h7E;
    localparam logic [STAT_W-1:0] ENG_CLR_MASK = 8'h44;
    localparam logic [STAT_W-1:0] ERR_MASK     = 8'h3A;
    localparam logic [STAT_W-1:0] RESET_VAL    = 8'h80;

    typedef logic [STAT_W-1:0] stat_t;

    typedef struct packed {
        stat_t set_bits;
        stat_t clr_bits;
        logic  busy;
        logic  clr_cmd;
    } upd_t;

    typedef enum logic [1:0] {
        BK_RSV  = 2'd0,
        BK_RDY  = 2'd1,
        BK_ERR  = 2'd2,
        BK_FLAG = 2'd3
    } bit_kind_t;

    typedef enum logic {
        RD_OPEN = 1'b0,
        RD_HELD = 1'b1
    } rd_st_t;

    function automatic bit_kind_t bit_kind(input int idx);
        if (idx == RDY_IDX)       return BK_RDY;
        else if (ERR_MASK[idx])   return BK_ERR;
        else if (SET_MASK[idx])   return BK_FLAG;
        else                      return BK_RSV;
    endfunction

endpackage

// File: rtl/flsr_bits.sv
module flsr_bits
    import flsr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  upd_t  upd,
    output stat_t stat
);

    for (genvar i = 0; i < STAT_W; i++) begin : g_bit
        localparam bit_kind_t KIND = bit_kind(i);
        if (KIND == BK_RSV) begin : g_rsv
            assign stat[i] = 1'b0;
        end else if (KIND == BK_RDY) begin : g_rdy
            logic b_q;
            always_ff @(posedge clk) begin
                if (rst) b_q <= RESET_VAL[i];
                else     b_q <= ~upd.busy;
            end
            assign stat[i] = b_q;
        end else if (KIND == BK_ERR) begin : g_err
            logic b_q;
            always_ff @(posedge clk) begin
                if (rst)                  b_q <= RESET_VAL[i];
                else if (upd.set_bits[i]) b_q <= 1'b1;
                else if (upd.clr_cmd)     b_q <= 1'b0;
            end
            assign stat[i] = b_q;
        end else begin : g_flag
            logic b_q;
            always_ff @(posedge clk) begin
                if (rst)                  b_q <= RESET_VAL[i];
                else if (upd.set_bits[i]) b_q <= 1'b1;
                else if (upd.clr_bits[i]) b_q <= 1'b0;
            end
            assign stat[i] = b_q;
        end
    end

    logic unused_bits;
    assign unused_bits = ^(upd.set_bits & ~SET_MASK) ^ ^(upd.clr_bits & ~ENG_CLR_MASK);

    // R2: ready flag follows the inverse of busy one edge later
    a_r2_ready_tracks: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> stat[RDY_IDX] == !$past(upd.busy));

    // R3: without a clear command an error flag never drops
    a_r3_err_sticky: assert property (@(posedge clk) disable iff (rst)
        !upd.clr_cmd |=> ((stat & $past(stat) & ERR_MASK) == ($past(stat) & ERR_MASK)));

    // R4: a clear command without a competing set empties the error flags
    a_r4_clear_errs: assert property (@(posedge clk) disable iff (rst)
        (upd.clr_cmd && ((upd.set_bits & ERR_MASK) == '0)) |=> ((stat & ERR_MASK) == '0));

    // R5/R6: every requested set lands, whatever clear came with it
    a_r6_set_wins: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((stat & $past(upd.set_bits & SET_MASK)) == $past(upd.set_bits & SET_MASK)));

endmodule

// File: rtl/flsr_rd_latch.sv
module flsr_rd_latch
    import flsr_pkg::*;
#(
    parameter int OUT_W = BUS_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ce_n,
    input  logic             oe_n,
    input  stat_t            stat_in,
    output logic [OUT_W-1:0] dq
);

    localparam int PAD_W = OUT_W - STAT_W;

    rd_st_t rd_q;
    stat_t  cap_q;
    logic   both_low;

    assign both_low = !ce_n && !oe_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q  <= RD_OPEN;
            cap_q <= '0;
        end else if (!both_low) begin
            rd_q  <= RD_OPEN;
        end else if (rd_q == RD_OPEN) begin
            rd_q  <= RD_HELD;
            cap_q <= stat_in;
        end
    end

    always_comb begin
        dq = '0;
        if (rd_q == RD_HELD) dq = {{PAD_W{1'b0}}, cap_q};
    end

    // R8: captured word does not move while the read is held
    a_r8_hold_stable: assert property (@(posedge clk) disable iff (rst)
        (rd_q == RD_HELD && both_low) |=> $stable(cap_q));

endmodule

// File: rtl/flsr_status.sv
module flsr_status
    import flsr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [STAT_W-1:0] eng_set,
    input  logic [STAT_W-1:0] eng_clr,
    input  logic              eng_busy,
    input  logic              clr_cmd,
    input  logic              ce_n,
    input  logic              oe_n,
    output logic [BUS_W-1:0]  dq
);

    upd_t  upd;
    stat_t stat;

    always_comb begin
        upd.set_bits = eng_set;
        upd.clr_bits = eng_clr;
        upd.busy     = eng_busy;
        upd.clr_cmd  = clr_cmd;
    end

    flsr_bits u_bits (
        .clk  (clk),
        .rst  (rst),
        .upd  (upd),
        .stat (stat)
    );

    flsr_rd_latch #(.OUT_W(BUS_W)) u_rd (
        .clk     (clk),
        .rst     (rst),
        .ce_n    (ce_n),
        .oe_n    (oe_n),
        .stat_in (stat),
        .dq      (dq)
    );

    // R9: an enable high at an edge blanks the bus after it
    a_r9_idle_zero: assert property (@(posedge clk) disable iff (rst)
        (ce_n || oe_n) |=> dq == '0);

    // R10: upper byte is never driven with data
    a_r10_upper_zero: assert property (@(posedge clk) disable iff (rst)
        dq[BUS_W-1:STAT_W] == '0);

    // R7: reserved bit reads zero
    a_r7_bit0_zero: assert property (@(posedge clk) disable iff (rst)
        dq[0] == 1'b0);

endmodule

// File: tb/sim_flsr_status.sv
`timescale 1ns/1ps
module sim_flsr_status;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  eng_set = '0;
    logic [7:0]  eng_clr = '0;
    logic        eng_busy = 1'b0;
    logic        clr_cmd = 1'b0;
    logic        ce_n = 1'b1;
    logic        oe_n = 1'b1;
    logic [15:0] dq;

    int checks = 0;
    int errors = 0;

    // bench-side model
    logic [7:0] m_stat = 8'h80;
    logic       m_held = 1'b0;
    logic [7:0] m_cap  = 8'h00;

    always #10 clk = ~clk;

    flsr_status u0 (
        .clk(clk), .rst(rst), .eng_set(eng_set), .eng_clr(eng_clr),
        .eng_busy(eng_busy), .clr_cmd(clr_cmd), .ce_n(ce_n), .oe_n(oe_n), .dq(dq)
    );

    function automatic logic [7:0] model_next(logic [7:0] cur, logic [7:0] s,
                                              logic [7:0] c, logic b, logic cmd);
        logic [7:0] n;
        n = cur;
        if (c[2]) n[2] = 1'b0;
        if (c[6]) n[6] = 1'b0;
        if (cmd) begin n[1] = 1'b0; n[3] = 1'b0; n[4] = 1'b0; n[5] = 1'b0; end
        for (int k = 1; k <= 6; k++) if (s[k]) n[k] = 1'b1;
        n[7] = ~b;
        n[0] = 1'b0;
        return n;
    endfunction

    function automatic logic [15:0] model_dq();
        return m_held ? {8'h00, m_cap} : 16'h0000;
    endfunction

    task automatic chk(input logic [15:0] got, input logic [15:0] exp, input string tag);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: dq=%h expected %h at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic tick(input logic [7:0] s, input logic [7:0] c, input logic b,
                        input logic cmd, input logic ce, input logic oe);
        logic [7:0] ns;
        logic       nh;
        logic [7:0] nc;
        eng_set = s; eng_clr = c; eng_busy = b; clr_cmd = cmd; ce_n = ce; oe_n = oe;
        if (rst) begin
            ns = 8'h80; nh = 1'b0; nc = 8'h00;
        end else begin
            ns = model_next(m_stat, s, c, b, cmd);
            nh = !ce && !oe;
            nc = (!ce && !oe && !m_held) ? m_stat : m_cap;
        end
        @(posedge clk);
        m_stat = ns; m_held = nh; m_cap = nc;
        @(negedge clk);
        chk(dq, model_dq(), "R8 R9 model");
        checks++;
        if (dq[15:8] !== 8'h00) begin
            errors++;
            $display("FAIL R10: dq[15:8]=%h expected 00", dq[15:8]);
        end
    endtask

    task automatic upd(input logic [7:0] s, input logic [7:0] c, input logic b, input logic cmd);
        tick(s, c, b, cmd, 1'b1, 1'b1);
    endtask

    task automatic rd(input logic b, input logic [15:0] exp, input string tag);
        tick(8'h00, 8'h00, b, 1'b0, 1'b0, 1'b0);
        chk(dq, exp, tag);
        tick(8'h00, 8'h00, b, 1'b0, 1'b1, 1'b1);
        chk(dq, 16'h0000, "R9 release");
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int unsigned seed;
        logic [31:0] r;
        seed = 32'd20240607;
        r = $urandom(seed);
        repeat (3) tick(8'h00, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1);
        rst = 1'b0;
        tick(8'h00, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1);
        chk(dq, 16'h0000, "R1 idle after reset");
        rd(1'b0, 16'h0080, "R1 first read");

        upd(8'h0A, 8'h00, 1'b1, 1'b0);
        rd(1'b1, 16'h000A, "R2 R3 busy with errors");
        upd(8'h00, 8'hFF, 1'b1, 1'b0);
        rd(1'b1, 16'h000A, "R3 engine clear ignored");
        upd(8'h44, 8'h00, 1'b0, 1'b0);
        rd(1'b0, 16'h00CE, "R5 flags set");
        upd(8'h00, 8'h44, 1'b0, 1'b0);
        rd(1'b0, 16'h008A, "R5 flags cleared");
        upd(8'h04, 8'h04, 1'b0, 1'b0);
        rd(1'b0, 16'h008E, "R5 set beats clear");
        upd(8'h00, 8'h00, 1'b0, 1'b1);
        rd(1'b0, 16'h0084, "R4 clear command");
        upd(8'h10, 8'h00, 1'b0, 1'b1);
        rd(1'b0, 16'h0094, "R6 set beats command");
        upd(8'h01, 8'h00, 1'b0, 1'b0);
        rd(1'b0, 16'h0094, "R7 reserved bit");

        // held read across updates
        tick(8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0);
        chk(dq, 16'h0094, "R8 capture");
        tick(8'h20, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0);
        chk(dq, 16'h0094, "R8 hold");
        tick(8'h00, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0);
        chk(dq, 16'h0094, "R11 busy hidden");
        tick(8'h00, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1);
        chk(dq, 16'h0000, "R9 oe raised");
        rd(1'b1, 16'h0034, "R11 visible after toggle");

        // oe falls first, ce later; status changes between
        tick(8'h08, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0);
        chk(dq, 16'h0000, "R9 only oe low");
        tick(8'h00, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0);
        chk(dq, 16'h003C, "R8 capture at later fall");
        tick(8'h00, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0);
        chk(dq, 16'h0000, "R9 ce raised");

        for (int n = 0; n < 4000; n++) begin
            logic [7:0] s;
            logic [7:0] c;
            logic       b, cmd, ce, oe;
            r = $urandom;
            s   = (r[3:0] == 4'd0) ? $urandom : 8'h00;
            c   = (r[7:4] < 4'd3) ? $urandom : 8'h00;
            b   = r[8] & r[9];
            cmd = (r[13:10] == 4'd0);
            ce  = (r[16:14] == 3'd0);
            oe  = (r[19:17] == 3'd0);
            tick(s, c, b, cmd, ce, oe);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule